// File: doc/BRIEF.md
# Mode-Dependent Interrupt Arbitration Unit

This unit sits beside the instruction sequencer of a small 8-bit processor core. It takes a set of level-style interrupt requests and qualifies each one with its mask. The requests are an illegal-opcode trap, a software interrupt, an external non-maskable line, an external level-sensitive line and a parameterised group of on-chip peripheral requests. The masks are a local enable per on-chip source, a global maskable-interrupt bit (the I bit) and a separate mask bit for the non-maskable line (the X bit). The unit picks the most urgent survivor by fixed priority. When the sequencer acknowledges, it latches the 16-bit address of that source's two-byte vector slot. The table base follows the operating mode. The unit also reports whether the vector fetch is served by the internal boot ROM or by external memory.

The I and X bits live in this unit. Software writes them through a small write port. Hardware sets them automatically when a request is accepted. The X bit starts set and can be cleared by software, but no software write can set it again. Only accepting a non-maskable request sets it again.

The control path is a three-state machine. ST_IDLE waits for any qualified request and moves to ST_PEND (transition "request seen"). ST_PEND raises `int_req`. It returns to ST_IDLE if the request is withdrawn ("request withdrawn"), or moves to ST_FETCH when `vec_ack` arrives while a request is still qualified ("accept"). ST_FETCH holds `vec_valid` and the latched vector and ignores new requests. It returns to ST_IDLE on `fetch_done` ("fetch complete").

Top module: `intc_vec_arbiter`

## Requirements
- R1: After reset `i_mask` and `x_mask` are 1, `int_req` and `vec_valid` are 0.
- R2: The external level line and every on-chip source qualify only while `i_mask` is 0, and an on-chip source also needs its bit of `chip_en` set; a request held low to high stays pending as long as it is held.
- R3: The non-maskable line qualifies only while `x_mask` is 0; a software write with `wdata_x`=0 clears `x_mask`, a write with `wdata_x`=1 leaves it unchanged.
- R4: The illegal-opcode trap and the software interrupt qualify regardless of `i_mask` and `x_mask`.
- R5: Priority, highest first: illegal opcode, software interrupt, non-maskable line, external level line, on-chip source 0, 1, 2 and so on; source k (in that order, from 0) owns the slot at table offset 0x3E - 2*(k+3), so the four fixed sources sit at offsets 0x38, 0x36, 0x34, 0x32 and on-chip source n at 0x30 - 2n.
- R6: The table base is 0xFFC0 when `op_mode` is 2'b00 or 2'b01, and 0xBFC0 when it is 2'b10 (bootstrap) or 2'b11 (special test).
- R7: `vec_rom` is 1 only for a vector latched in mode 2'b10.
- R8: State sequence: a qualified request raises `int_req` one cycle later; withdrawing it before acknowledge drops `int_req` one cycle later; `vec_ack` while `int_req` and a request is qualified raises `vec_valid` one cycle later and drops `int_req`; `fetch_done` drops `vec_valid` one cycle later; `vec_ack` with nothing qualified does nothing.
- R9: `vec_addr` and `vec_rom` change only on an accepted acknowledge; requests raised while `vec_valid` is 1 neither change them nor raise `int_req`.
- R10: Accepting the non-maskable line, the external level line or an on-chip source sets `i_mask`; accepting the non-maskable line also sets `x_mask`; accepting the trap or the software interrupt leaves both unchanged. The change is visible together with `vec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | Operating mode: 00/01 normal, 10 bootstrap, 11 special test |
| illop_req | input | 1 | Illegal-opcode trap request |
| swi_req | input | 1 | Software interrupt request |
| xirq_req | input | 1 | External non-maskable line (active high) |
| irq_req | input | 1 | External level-sensitive maskable line (active high) |
| chip_req | input | N_CHIP | On-chip peripheral requests |
| chip_en | input | N_CHIP | Local enable per on-chip source |
| wr_i | input | 1 | Software write strobe for the I bit |
| wdata_i | input | 1 | Value written to the I bit |
| wr_x | input | 1 | Software write strobe for the X bit |
| wdata_x | input | 1 | Value written to the X bit (only 0 has effect) |
| vec_ack | input | 1 | Sequencer acknowledge of `int_req` |
| fetch_done | input | 1 | Sequencer finished the vector fetch |
| int_req | output | 1 | Interrupt request to the sequencer |
| vec_valid | output | 1 | Latched vector is being fetched |
| vec_addr | output | 16 | Latched vector slot address |
| vec_rom | output | 1 | Vector served by internal boot ROM |
| i_mask | output | 1 | Current I bit |
| x_mask | output | 1 | Current X bit |

## Verification
The embedded properties assume the sequencer obeys the handshake. It raises `fetch_done` only while `vec_valid` is set, and it does not expect a vector in a cycle where it did not acknowledge. They also assume `op_mode` is steady around the acknowledge it applies to. The directed stimulus drives every input half a cycle away from the sampling edge. It pulses `vec_ack` only after `int_req` is seen and `fetch_done` only during a fetch, and it withdraws request lines while the fetch is under way so that the next arbitration starts from a known set of requests.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_FETCH = 2'd2
    } arb_state_e;

    localparam logic [1:0] MD_BOOT = 2'b10;

    // Fixed source positions in priority order (lowest index wins).
    localparam int SRC_ILLOP = 0;
    localparam int SRC_SWI   = 1;
    localparam int SRC_XIRQ  = 2;
    localparam int SRC_IRQ   = 3;
    localparam int SRC_CHIP0 = 4;

    // Slots at the top of the table kept for reset-class vectors.
    localparam int RSVD_SLOTS = 3;
    localparam int TOP_OFFSET = 62;

    function automatic logic [5:0] slot_offset(input int src);
        return 6'(TOP_OFFSET - 2 * (src + RSVD_SLOTS));
    endfunction

endpackage

// File: rtl/intc_qualify.sv
module intc_qualify #(
    parameter int N_CHIP = 19,
    localparam int N_SRC = intc_pkg::SRC_CHIP0 + N_CHIP
) (
    input  logic              illop_req,
    input  logic              swi_req,
    input  logic              xirq_req,
    input  logic              irq_req,
    input  logic [N_CHIP-1:0] chip_req,
    input  logic [N_CHIP-1:0] chip_en,
    input  logic              i_mask,
    input  logic              x_mask,
    output logic [N_SRC-1:0]  pend
);
    import intc_pkg::*;

    assign pend[SRC_ILLOP] = illop_req;
    assign pend[SRC_SWI]   = swi_req;
    assign pend[SRC_XIRQ]  = xirq_req & ~x_mask;
    assign pend[SRC_IRQ]   = irq_req  & ~i_mask;

    for (genvar n = 0; n < N_CHIP; n++) begin : g_chip
        assign pend[SRC_CHIP0 + n] = chip_req[n] & chip_en[n] & ~i_mask;
    end

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N_SRC = 23,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N_SRC-1:0] blocked;
    logic [N_SRC-1:0] grant;

    assign blocked[0] = 1'b0;
    assign grant[0]   = pend[0];
    for (genvar k = 1; k < N_SRC; k++) begin : g_chain
        assign blocked[k] = blocked[k-1] | pend[k-1];
        assign grant[k]   = pend[k] & ~blocked[k];
    end

    assign any = |pend;

    always_comb begin
        idx = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (grant[k]) idx = IDX_W'(k);
        end
    end

    // R5
    winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> pend[idx]);

    // R5
    winner_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any && idx != '0) |-> (pend & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0);

endmodule

// File: rtl/intc_vecmap.sv
module intc_vecmap #(
    parameter int N_SRC = 23,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [1:0]       op_mode,
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      addr,
    output logic             rom
);
    import intc_pkg::*;

    logic [5:0] off;
    logic [9:0] base_hi;

    assign off     = 6'(TOP_OFFSET - 2 * (int'(idx) + RSVD_SLOTS));
    assign base_hi = op_mode[1] ? 10'(16'hBFC0 >> 6) : 10'(16'hFFC0 >> 6);
    assign addr    = {base_hi, off};
    assign rom     = (op_mode == MD_BOOT);

endmodule

// File: rtl/intc_masks.sv
module intc_masks (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic wr_x,
    input  logic wdata_x,
    input  logic set_i,
    input  logic set_x,
    output logic i_mask,
    output logic x_mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_mask <= 1'b1;
            x_mask <= 1'b1;
        end else begin
            if (set_i)     i_mask <= 1'b1;
            else if (wr_i) i_mask <= wdata_i;

            if (set_x)                 x_mask <= 1'b1;
            else if (wr_x && !wdata_x) x_mask <= 1'b0;
        end
    end

    // R3
    x_sw_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_mask && !set_x) |=> !x_mask);

    // R10
    i_hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> i_mask);

endmodule

// File: rtl/intc_vec_arbiter.sv
module intc_vec_arbiter #(
    parameter int N_CHIP = 19,
    localparam int N_SRC = intc_pkg::SRC_CHIP0 + N_CHIP,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_mode,
    input  logic              illop_req,
    input  logic              swi_req,
    input  logic              xirq_req,
    input  logic              irq_req,
    input  logic [N_CHIP-1:0] chip_req,
    input  logic [N_CHIP-1:0] chip_en,
    input  logic              wr_i,
    input  logic              wdata_i,
    input  logic              wr_x,
    input  logic              wdata_x,
    input  logic              vec_ack,
    input  logic              fetch_done,
    output logic              int_req,
    output logic              vec_valid,
    output logic [15:0]       vec_addr,
    output logic              vec_rom,
    output logic              i_mask,
    output logic              x_mask
);
    import intc_pkg::*;

    localparam logic [5:0] XIRQ_OFF = slot_offset(SRC_XIRQ);

    arb_state_e       state_q, state_d;
    logic [N_SRC-1:0] pend;
    logic             any_pend;
    logic [IDX_W-1:0] win_idx;
    logic [15:0]      map_addr;
    logic             map_rom;
    logic             take;
    logic             set_i, set_x;

    intc_qualify #(.N_CHIP(N_CHIP)) u_qual (
        .illop_req (illop_req),
        .swi_req   (swi_req),
        .xirq_req  (xirq_req),
        .irq_req   (irq_req),
        .chip_req  (chip_req),
        .chip_en   (chip_en),
        .i_mask    (i_mask),
        .x_mask    (x_mask),
        .pend      (pend)
    );

    intc_prio #(.N_SRC(N_SRC)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .any   (any_pend),
        .idx   (win_idx)
    );

    intc_vecmap #(.N_SRC(N_SRC)) u_map (
        .op_mode (op_mode),
        .idx     (win_idx),
        .addr    (map_addr),
        .rom     (map_rom)
    );

    assign take  = (state_q == ST_PEND) && vec_ack && any_pend;
    assign set_i = take && (win_idx >= IDX_W'(SRC_XIRQ));
    assign set_x = take && (win_idx == IDX_W'(SRC_XIRQ));

    intc_masks u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_i),
        .wdata_i (wdata_i),
        .wr_x    (wr_x),
        .wdata_x (wdata_x),
        .set_i   (set_i),
        .set_x   (set_x),
        .i_mask  (i_mask),
        .x_mask  (x_mask)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_pend) state_d = ST_PEND;
            ST_PEND: begin
                if (!any_pend)    state_d = ST_IDLE;
                else if (vec_ack) state_d = ST_FETCH;
            end
            ST_FETCH: if (fetch_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output process: latched vector and handshake levels.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_addr <= '0;
            vec_rom  <= 1'b0;
        end else if (take) begin
            vec_addr <= map_addr;
            vec_rom  <= map_rom;
        end
    end

    assign int_req   = (state_q == ST_PEND);
    assign vec_valid = (state_q == ST_FETCH);

    // R9
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(vec_addr) && $stable(vec_rom)));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && vec_ack && any_pend) |=> (vec_valid && !int_req));

    // R10
    x_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x_mask) |-> (vec_valid && vec_addr[5:0] == XIRQ_OFF));

    // R7
    rom_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rom |-> (vec_addr[15:12] == 4'hB));

endmodule

// File: tb/tb_intc_vec_arbiter.sv
module tb_intc_vec_arbiter;

    localparam int N_CHIP = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        op_mode = 2'b00;
    logic              illop_req = 0, swi_req = 0, xirq_req = 0, irq_req = 0;
    logic [N_CHIP-1:0] chip_req = '0, chip_en = '0;
    logic              wr_i = 0, wdata_i = 0, wr_x = 0, wdata_x = 0;
    logic              vec_ack = 0, fetch_done = 0;
    logic              int_req, vec_valid, vec_rom, i_mask, x_mask;
    logic [15:0]       vec_addr;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    intc_vec_arbiter #(.N_CHIP(N_CHIP)) dut (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode),
        .illop_req(illop_req), .swi_req(swi_req), .xirq_req(xirq_req),
        .irq_req(irq_req), .chip_req(chip_req), .chip_en(chip_en),
        .wr_i(wr_i), .wdata_i(wdata_i), .wr_x(wr_x), .wdata_x(wdata_x),
        .vec_ack(vec_ack), .fetch_done(fetch_done),
        .int_req(int_req), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .vec_rom(vec_rom), .i_mask(i_mask), .x_mask(x_mask)
    );

    // Expected address from R5/R6: source k in priority order.
    function automatic logic [15:0] exp_vec(input logic [1:0] md, input int k);
        return (md[1] ? 16'hBFC0 : 16'hFFC0) + 16'(62 - 2 * (k + 3));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_i(input logic v);
        wr_i = 1; wdata_i = v; step(); wr_i = 0;
    endtask

    task automatic write_x(input logic v);
        wr_x = 1; wdata_x = v; step(); wr_x = 0;
    endtask

    task automatic accept(input string tag, input logic [15:0] ea, input logic er);
        chk({tag, " int_req before ack"}, int_req, 1);
        vec_ack = 1; step(); vec_ack = 0;
        chk({tag, " vec_valid"}, vec_valid, 1);
        chk({tag, " int_req after ack"}, int_req, 0);
        chk({tag, " vec_addr"}, vec_addr, ea);
        chk({tag, " vec_rom"}, vec_rom, er);
    endtask

    task automatic finish_fetch();
        fetch_done = 1; step(); fetch_done = 0;
        chk("R8 vec_valid drops", vec_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1 i_mask", i_mask, 1);
        chk("R1 x_mask", x_mask, 1);
        chk("R1 int_req", int_req, 0);
        chk("R1 vec_valid", vec_valid, 0);
    endtask

    task automatic t_irq_level();
        irq_req = 1; step(); step();
        chk("R2 irq blocked by I", int_req, 0);
        write_i(0); step();
        chk("R2 irq pending", int_req, 1);
        step();
        chk("R2 irq level held", int_req, 1);
        accept("R5 irq", exp_vec(2'b00, 3), 0);
        chk("R10 irq sets I", i_mask, 1);
        irq_req = 0; finish_fetch();
    endtask

    task automatic t_chip_enable();
        write_i(0);
        chip_req[5] = 1; step(); step();
        chk("R2 chip needs enable", int_req, 0);
        chip_en[5] = 1; step();
        accept("R5 chip5", exp_vec(2'b00, 9), 0);
        chk("R5 chip5 offset", vec_addr[5:0], 6'h26);
        chk("R10 chip sets I", i_mask, 1);
        chip_req = '0; finish_fetch();
        chip_req[5] = 1; step(); step();
        chk("R2 chip blocked by I", int_req, 0);
        chip_req = '0;
    endtask

    task automatic t_chip_order();
        chip_en = '1;
        chip_req[7] = 1; chip_req[2] = 1;
        write_i(0); step();
        accept("R5 chip2 over chip7", exp_vec(2'b00, 6), 0);
        chip_req = '0; chip_en = '0; finish_fetch();
    endtask

    task automatic t_xirq();
        xirq_req = 1; step(); step();
        chk("R3 xirq blocked by X", int_req, 0);
        write_x(0); step();
        accept("R5 xirq", exp_vec(2'b00, 2), 0);
        chk("R10 xirq sets X", x_mask, 1);
        chk("R10 xirq sets I", i_mask, 1);
        xirq_req = 0; finish_fetch();
        write_x(0);
        chk("R3 x cleared", x_mask, 0);
        write_x(1);
        chk("R3 x write 1 ignored", x_mask, 0);
    endtask

    task automatic t_priority();
        write_i(0);
        chip_en[0] = 1;
        illop_req = 1; swi_req = 1; irq_req = 1; chip_req[0] = 1; step();
        accept("R5 illop first", exp_vec(2'b00, 0), 0);
        chk("R10 illop keeps I", i_mask, 0);
        illop_req = 0; finish_fetch(); step();
        accept("R5 swi second", exp_vec(2'b00, 1), 0);
        chk("R10 swi keeps I", i_mask, 0);
        swi_req = 0; finish_fetch(); step();
        accept("R5 irq over chip0", exp_vec(2'b00, 3), 0);
        irq_req = 0; chip_req = '0; chip_en = '0; finish_fetch();
        chk("R10 I after irq", i_mask, 1);
        swi_req = 1; step();
        accept("R4 swi with I set", exp_vec(2'b00, 1), 0);
        swi_req = 0; finish_fetch();
        write_x(0);
        illop_req = 1; step();
        accept("R4 illop with I set", exp_vec(2'b00, 0), 0);
        chk("R10 illop keeps X", x_mask, 0);
        illop_req = 0; finish_fetch();
    endtask

    task automatic t_modes();
        for (int m = 1; m < 4; m++) begin
            op_mode = 2'(m);
            swi_req = 1; step();
            accept("R6 R7 mode vector", exp_vec(2'(m), 1), (m == 2));
            swi_req = 0; finish_fetch();
        end
        op_mode = 2'b00;
    endtask

    task automatic t_fetch_hold();
        swi_req = 1; step();
        accept("R9 base", exp_vec(2'b00, 1), 0);
        swi_req = 0; illop_req = 1; op_mode = 2'b10; step(); step();
        chk("R9 addr held in fetch", vec_addr, exp_vec(2'b00, 1));
        chk("R9 rom held in fetch", vec_rom, 0);
        chk("R9 no int_req in fetch", int_req, 0);
        op_mode = 2'b00;
        finish_fetch(); step();
        accept("R9 waits then wins", exp_vec(2'b00, 0), 0);
        illop_req = 0; finish_fetch();
    endtask

    task automatic t_withdraw();
        write_i(0);
        irq_req = 1; step();
        chk("R8 int_req raised", int_req, 1);
        irq_req = 0; step();
        chk("R8 withdraw drops int_req", int_req, 0);
        vec_ack = 1; step(); vec_ack = 0;
        chk("R8 stray ack ignored", vec_valid, 0);
        chk("R8 stray ack keeps I", i_mask, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_irq_level();
        t_chip_enable();
        t_chip_order();
        t_xirq();
        t_priority();
        t_modes();
        t_fetch_hold();
        t_withdraw();
        done_flag = 1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule